// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

This block is a single 16-bit counting channel of an interval timer. It advances on cycles where the count-clock enable is high, takes a new initial count through a load strobe, and takes its operating mode through a separate mode-write strobe. Its output waveform is one of six shapes: a terminal-count flag, a retriggerable one-shot, a rate-generator pulse train, a square wave, and a strobe that is either software-started or gate-started.

The channel follows the number of enabled ticks since the last restart, called d below. A restart is a load, a mode write or a gate trigger. The loaded length N is the load value, and a load value of zero means 65536. The output level and the count that can be read back are pure functions of the mode, N and d. The gate input has two meanings. In the terminal-count and software-strobe modes its level pauses counting. In the other modes its rising edge restarts counting from the loaded value. BCD counting and any register bus are outside this block.

Top module: `mmt_channel`

## Requirements
- R1: A load sets N to the load value, with 0 meaning 65536, and restarts d at 0. From the next cycle the count output shows N modulo 65536, so a zero load reads 0.
- R2: In mode 0 the output is low while d < N and high once d >= N, and it stays high. In modes 0, 1, 4 and 5 the count output is (N - d) modulo 65536, falling by one per tick.
- R3: Mode 1 drives the output with the same rule as mode 0, and a gate rising edge restarts it.
- R4: In mode 2 the output is high exactly when d is a nonzero multiple of N, and the count output is N - (d mod N), truncated to 16 bits.
- R5: In mode 3 the output is high while (d mod N) < (N+1)/2, so an odd N gives (N+1)/2 high ticks and (N-1)/2 low ticks. The count output is N - ((2d) mod N), truncated to 16 bits.
- R6: In modes 4 and 5 the output is high only on the tick where d equals N.
- R7: In modes 1, 2, 3 and 5 a rising edge of the gate, sampled at the clock, sets d to 0, and a tick in that same cycle is discarded. In modes 0 and 4 a low gate holds d, and a gate rising edge does not restart.
- R8: On a cycle with tick_en low, and with no load, mode write or gate restart, neither output changes.
- R9: A mode write sets d to 0 and stops counting until the next load. The output then rests at its d = 0 level, which is high in mode 3 and low in all other modes. Codes 6 and 7 act as modes 2 and 3. A mode write and a load in the same cycle both take effect.
- R10: After reset the mode is 0, N is 65536, counting is stopped, the count output reads 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-clock enable; one tick per high cycle |
| gate_i | input | 1 | Gate: level enable or rising-edge trigger, depending on mode |
| load_i | input | 1 | Load strobe for a new initial count |
| load_val_i | input | 16 | Initial count; 0 means 65536 |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code 0..7 |
| count_o | output | 16 | Count value as read back |
| out_o | output | 1 | Output pin level |

## Verification
Every mode code from 0 to 7 is combined with lengths 1, 2, 3, 5 and 6, and each pair runs for more than two periods with idle cycles mixed in. Comparing every cycle against the closed-form expressions in d separates wrap and reload errors, odd and even square-wave halves, and single-tick strobes from sticky levels. A gate sequence of low pulses followed by a rising edge is run in each mode, which tells the level-pause modes apart from the retrigger modes. Zero loads, long lengths in modes 2 and 3, and a mode write in the middle of a run cover the 65536 rule, wraparound over many periods, and the rest levels after a mode write.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    localparam logic [2:0] MODE_TERM    = 3'd0;
    localparam logic [2:0] MODE_ONESHOT = 3'd1;
    localparam logic [2:0] MODE_RATE    = 3'd2;
    localparam logic [2:0] MODE_SQUARE  = 3'd3;
    localparam logic [2:0] MODE_SWSTB   = 3'd4;
    localparam logic [2:0] MODE_HWSTB   = 3'd5;

    // codes 6 and 7 are aliases of the periodic modes
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic logic is_retrig(input logic [2:0] m);
        return (m == MODE_ONESHOT) || (m == MODE_RATE) ||
               (m == MODE_SQUARE)  || (m == MODE_HWSTB);
    endfunction

    function automatic logic is_level(input logic [2:0] m);
        return (m == MODE_TERM) || (m == MODE_SWSTB);
    endfunction

endpackage

// File: rtl/mmt_gate_ctl.sv
module mmt_gate_ctl
    import mmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_i,
    input  logic       tick_en,
    input  logic       run_en_i,
    input  logic [2:0] mode_i,
    output logic       restart_o,
    output logic       advance_o
);

    logic gate_d, gate_q;

    always_comb begin
        gate_d    = gate_i;
        restart_o = run_en_i && is_retrig(mode_i) && gate_i && !gate_q;
        advance_o = run_en_i && tick_en && !restart_o &&
                    (is_level(mode_i) ? gate_i : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

endmodule

// File: rtl/mmt_phase.sv
module mmt_phase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          advance_i,
    input  logic [CW:0]   len_i,
    output logic [CW:0]   ph_o,
    output logic [CW-1:0] sq_o,
    output logic [CW-1:0] free_o,
    output logic          started_o,
    output logic          done_o,
    output logic          hit_o
);

    localparam int NW = CW + 1;

    typedef struct packed {
        logic [NW-1:0] ph;
        logic [NW-1:0] sq;
        logic [CW-1:0] free;
        logic          started;
        logic          done;
        logic          hit;
    } phase_s;

    phase_s st_d, st_q;
    logic [NW-1:0] ph_inc, sq_a, sq_b;
    logic          wrap;

    always_comb begin
        st_d   = st_q;
        ph_inc = st_q.ph + NW'(1);
        wrap   = (ph_inc == len_i);
        sq_a   = st_q.sq + NW'(2);
        if (sq_a >= len_i) sq_a = sq_a - len_i;
        sq_b   = sq_a;
        if (sq_b >= len_i) sq_b = sq_b - len_i;
        if (clear_i) begin
            st_d.ph      = '0;
            st_d.sq      = '0;
            st_d.free    = len_i[CW-1:0];
            st_d.started = 1'b0;
            st_d.done    = 1'b0;
            st_d.hit     = 1'b0;
        end else if (advance_i) begin
            st_d.ph      = wrap ? '0 : ph_inc;
            st_d.sq      = sq_b;
            st_d.free    = st_q.free - CW'(1);
            st_d.started = 1'b1;
            st_d.hit     = wrap && !st_q.done;
            st_d.done    = st_q.done || wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.free <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_o      = st_q.ph;
    assign sq_o      = st_q.sq[CW-1:0];
    assign free_o    = st_q.free;
    assign started_o = st_q.started;
    assign done_o    = st_q.done;
    assign hit_o     = st_q.hit;

    assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (st_q.ph < len_i));

    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clear_i) |=> st_q.done);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hit && advance_i && !clear_i) |=> !st_q.hit);

endmodule

// File: rtl/mmt_out_dec.sv
module mmt_out_dec
    import mmt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [2:0]    mode_i,
    input  logic [CW:0]   len_i,
    input  logic [CW:0]   ph_i,
    input  logic [CW-1:0] sq_i,
    input  logic [CW-1:0] free_i,
    input  logic          started_i,
    input  logic          done_i,
    input  logic          hit_i,
    output logic [CW-1:0] count_o,
    output logic          out_o
);

    localparam int NW = CW + 1;

    logic [NW-1:0] half;

    always_comb begin
        half = (len_i + NW'(1)) >> 1;
        unique case (mode_i)
            MODE_RATE: begin
                out_o   = started_i && (ph_i == '0);
                count_o = len_i[CW-1:0] - ph_i[CW-1:0];
            end
            MODE_SQUARE: begin
                out_o   = (ph_i < half);
                count_o = len_i[CW-1:0] - sq_i;
            end
            MODE_SWSTB, MODE_HWSTB: begin
                out_o   = hit_i;
                count_o = free_i;
            end
            default: begin
                out_o   = done_i;
                count_o = free_i;
            end
        endcase
    end

endmodule

// File: rtl/mmt_channel.sv
module mmt_channel
    import mmt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          gate_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          mode_wr_i,
    input  logic [2:0]    mode_i,
    output logic [CW-1:0] count_o,
    output logic          out_o
);

    localparam int            NW   = CW + 1;
    localparam logic [NW-1:0] FULL = NW'(1) << CW;

    typedef struct packed {
        logic [2:0]    mode;
        logic [NW-1:0] len;
        logic          armed;
    } chan_s;

    chan_s st_d, st_q;
    logic  run_en, restart, advance, clear;
    logic [NW-1:0] ph;
    logic [CW-1:0] sq, free;
    logic          started, done, hit;

    always_comb begin
        st_d = st_q;
        if (mode_wr_i) begin
            st_d.mode  = fold_mode(mode_i);
            st_d.armed = 1'b0;
        end
        if (load_i) begin
            st_d.len   = (load_val_i == '0) ? FULL : {1'b0, load_val_i};
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_TERM;
            st_q.len   <= FULL;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_en = st_q.armed && !load_i && !mode_wr_i;
    assign clear  = load_i || mode_wr_i || restart;

    mmt_gate_ctl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_i    (gate_i),
        .tick_en   (tick_en),
        .run_en_i  (run_en),
        .mode_i    (st_q.mode),
        .restart_o (restart),
        .advance_o (advance)
    );

    mmt_phase #(.CW(CW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .advance_i (advance),
        .len_i     (st_d.len),
        .ph_o      (ph),
        .sq_o      (sq),
        .free_o    (free),
        .started_o (started),
        .done_o    (done),
        .hit_o     (hit)
    );

    mmt_out_dec #(.CW(CW)) u_dec (
        .mode_i    (st_q.mode),
        .len_i     (st_q.len),
        .ph_i      (ph),
        .sq_i      (sq),
        .free_i    (free),
        .started_i (started),
        .done_i    (done),
        .hit_i     (hit),
        .count_o   (count_o),
        .out_o     (out_o)
    );

    assert_zero_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (count_o == '0 && st_q.len == FULL));

    assert_mode_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && !load_i) |=> (out_o == (st_q.mode == MODE_SQUARE)));

    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && is_level(st_q.mode) && !gate_i && !load_i && !mode_wr_i)
        |=> ($stable(count_o) && $stable(out_o)));

    assert_retrig_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_o == st_q.len[CW-1:0]));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_i && !mode_wr_i && !restart)
        |=> ($stable(count_o) && $stable(out_o)));

endmodule

// File: tb/tb_mmt_channel.sv
module tb_mmt_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        gate_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_val_i = '0;
    logic        mode_wr_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [15:0] count_o;
    logic        out_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    longint md = 0;
    longint mn = 65536;
    int     mmode = 0;
    bit     marmed = 1'b0;
    bit     mgprev = 1'b0;

    always #2 clk = ~clk;

    mmt_channel dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .gate_i     (gate_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .mode_wr_i  (mode_wr_i),
        .mode_i     (mode_i),
        .count_o    (count_o),
        .out_o      (out_o)
    );

    function automatic int eff(input int m);
        return (m == 6) ? 2 : (m == 7) ? 3 : m;
    endfunction

    function automatic bit exp_out();
        case (mmode)
            2: return (md % mn == 0) && (md != 0);
            3: return (md % mn) < ((mn + 1) / 2);
            4, 5: return md == mn;
            default: return md >= mn;
        endcase
    endfunction

    function automatic longint exp_cnt();
        case (mmode)
            2: return (mn - (md % mn)) & 65535;
            3: return (mn - ((2 * md) % mn)) & 65535;
            default: return (((mn - md) % 65536) + 65536) % 65536;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (eff(m))
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag);
        longint ec;
        bit eo;
        ec = exp_cnt();
        eo = exp_out();
        checks++;
        if (count_o !== 16'(ec) || out_o !== eo) begin
            errors++;
            $display("FAIL %s mode=%0d n=%0d d=%0d: count=%0d out=%0b expected count=%0d out=%0b",
                     tag, mmode, mn, md, count_o, out_o, ec, eo);
        end
    endtask

    task automatic cyc(input logic ld, input logic [15:0] v, input logic mw,
                       input logic [2:0] m, input logic tk, input logic g,
                       input string tag);
        bit rise;
        @(negedge clk);
        load_i = ld; load_val_i = v; mode_wr_i = mw; mode_i = m;
        tick_en = tk; gate_i = g;
        @(posedge clk);
        rise = g && !mgprev;
        mgprev = g;
        if (mw) begin
            mmode = eff(int'(m)); md = 0; marmed = 1'b0;
        end
        if (ld) begin
            mn = (v == 0) ? 65536 : longint'(v); md = 0; marmed = 1'b1;
        end else if (marmed && !mw) begin
            if (rise && (mmode == 1 || mmode == 2 || mmode == 3 || mmode == 5))
                md = 0;
            else if (tk && ((mmode == 0 || mmode == 4) ? g : 1'b1))
                md++;
        end
        #1;
        check(tag);
    endtask

    task automatic tick(input logic g, input string tag);
        cyc(1'b0, 16'd0, 1'b0, 3'd0, 1'b1, g, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 16'd0, 1'b0, 3'd0, 1'b0, gate_i, tag);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog expired: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lens[5] = '{1, 2, 3, 5, 6};
        repeat (3) @(posedge clk);
        #1;
        check("R10");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10");

        // full sweep: every mode code against short lengths
        for (int m = 0; m < 8; m++) begin
            foreach (lens[i]) begin
                cyc(1'b0, 16'd0, 1'b1, 3'(m), 1'b0, 1'b1, "R9");
                cyc(1'b1, 16'(lens[i]), 1'b0, 3'd0, 1'b0, 1'b1, "R1");
                for (int t = 0; t < 2 * lens[i] + 4; t++) begin
                    if (t % 3 == 2) idle("R8");
                    tick(1'b1, mode_tag(m));
                end
            end
        end

        // gate behaviour in every mode
        for (int m = 0; m < 6; m++) begin
            cyc(1'b0, 16'd0, 1'b1, 3'(m), 1'b0, 1'b1, "R9");
            cyc(1'b1, 16'd6, 1'b0, 3'd0, 1'b0, 1'b1, "R1");
            tick(1'b1, "R7");
            tick(1'b1, "R7");
            tick(1'b0, "R7");
            tick(1'b0, "R7");
            tick(1'b1, "R7");
            for (int t = 0; t < 8; t++) tick(1'b1, "R7");
        end

        // zero load means 65536
        cyc(1'b0, 16'd0, 1'b1, 3'd0, 1'b0, 1'b1, "R9");
        cyc(1'b1, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, "R1");
        for (int t = 0; t < 5; t++) tick(1'b1, "R1");
        cyc(1'b1, 16'd0, 1'b1, 3'd3, 1'b0, 1'b1, "R9");
        for (int t = 0; t < 5; t++) tick(1'b1, "R1");

        // long lengths across several periods
        cyc(1'b1, 16'd1001, 1'b1, 3'd3, 1'b0, 1'b1, "R5");
        for (int t = 0; t < 2100; t++) tick(1'b1, "R5");
        cyc(1'b1, 16'd300, 1'b1, 3'd2, 1'b0, 1'b1, "R4");
        for (int t = 0; t < 700; t++) tick(1'b1, "R4");

        // mode write mid-run stops counting until a load
        cyc(1'b0, 16'd0, 1'b1, 3'd7, 1'b0, 1'b1, "R9");
        for (int t = 0; t < 4; t++) tick(1'b1, "R9");
        cyc(1'b0, 16'd0, 1'b1, 3'd1, 1'b0, 1'b1, "R9");
        for (int t = 0; t < 4; t++) tick(1'b1, "R9");
        cyc(1'b1, 16'd3, 1'b0, 3'd0, 1'b0, 1'b1, "R1");
        for (int t = 0; t < 5; t++) tick(1'b1, "R3");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule